// File: doc/BRIEF.md
# Segment Descriptor Fetch Unit

When a segment register is written with a 16-bit selector, this block fetches the selected 8-byte descriptor from a descriptor table in memory. A 48-bit table register supplies the table's base address and its byte boundary. The block reads the entry as two 32-bit words over a synchronous memory port. It reassembles the base and limit pieces that are spread across the entry, then checks the entry and either produces a valid cached descriptor or reports a fault.

A load starts with a one-cycle strobe. Its selector index is checked first for the null entry and for the table bound, and neither check touches memory. Entries that pass are fetched and then checked for the descriptor-type bit and the present bit. A successful load sets the accessed bit. When memory held that bit clear, the block writes the updated second word back. Completion is a single-cycle done pulse. While the block is busy, any further strobe is ignored.

Top module: `seg_desc_fetch`

## Requirements
- R1: After reset, busy, done and dsc_valid are 0, flt_kind is 0 and no memory request is issued.
- R2: tbl_reg[47:16] is the table base and tbl_reg[15:0] is the boundary. For selector index i the block reads address base+8*i in one request and then address base+8*i+4 in the next cycle. Read data returns one cycle after its request.
- R3: With word0 at the lower address and word1 at the upper address, the cached descriptor is unpacked as follows: limit = {word1[19:16], word0[15:0]}, base = {word1[31:24], word1[7:0], word0[31:16]}, access = word1[15:8], flags = word1[23:20].
- R4: Index 0 is the null entry. For a data register (ld_kind 0 or 3) it ends with dsc_valid=0 and flt_kind=0. For a code register (ld_kind 1) or a stack register (ld_kind 2) it ends with flt_kind=1 (general protection) and flt_code=0. In both cases memory is not accessed.
- R5: If 8*i+7 is greater than the boundary, the load ends with flt_kind=1 and flt_code={sel[15:3],3'b000}, and memory is not accessed. An entry whose last byte equals the boundary is accepted.
- R6: If access bit 4 (descriptor type) is 0, the load ends with flt_kind=1 and flt_code={sel[15:3],3'b000}. This check takes priority over the present check.
- R7: If access bit 4 is 1 and access bit 7 (present) is 0, the load ends with flt_kind=2 (not present) and flt_code={sel[15:3],3'b000}.
- R8: On success dsc_valid=1 and the cached access byte has bit 0 set. If bit 0 was clear in memory, word1 with bit 8 set is written to base+8*i+4 in the done cycle. Otherwise no write occurs. A faulting load writes nothing, and any fault clears dsc_valid.
- R9: Selector bits 2:0 have no effect on the address, the result or the fault code.
- R10: A load accepted at clock edge k gives a one-cycle done pulse after edge k+1 when it ends before fetching, and after edge k+4 when it fetches. busy is 1 from edge k until done rises. A strobe while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_req | input | 1 | Load strobe |
| ld_sel | input | 16 | Segment selector |
| ld_kind | input | 2 | Target register: 0 data, 1 code, 2 stack, 3 data |
| tbl_reg | input | 48 | Table base (47:16) and boundary (15:0) |
| busy | output | 1 | Load in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| dsc_valid | output | 1 | Cached descriptor valid |
| flt_kind | output | 2 | 0 none, 1 general protection, 2 not present |
| flt_code | output | 16 | Fault error code |
| dsc_base | output | 32 | Cached base |
| dsc_limit | output | 20 | Cached limit |
| dsc_access | output | 8 | Cached access byte |
| dsc_flags | output | 4 | Cached flags nibble |

## Verification
The bench builds the block with its default widths: 32-bit addresses and data, and 16-bit selector and boundary. It places the table at a small base in a 64-word memory model. It switches the boundary between a six-entry and an eight-entry table, so the last accepted entry and the first rejected entry both fall inside the model. The stored entries include split base and limit pieces, set and clear accessed bits, and present/system combinations that reach every fault path and the type-over-present priority.

// File: rtl/seg_desc_pkg.sv
package seg_desc_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int BND_W  = 16;
  localparam int IDX_W  = SEL_W - 3;
  localparam int TBL_W  = ADDR_W + BND_W;
  localparam int LIM_W  = 20;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_NP   = 2'd2
  } flt_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_RD1, S_WT, S_EVAL
  } st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [7:0]        access;
    logic [3:0]        flags;
  } desc_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_desc_pkg::*;
(
  input  logic [WORD_W-1:0] w_lo,
  input  logic [WORD_W-1:0] w_hi,
  output desc_t             dsc
);
  always_comb begin
    dsc.limit  = {w_hi[19:16], w_lo[15:0]};
    dsc.base   = {w_hi[31:24], w_hi[7:0], w_lo[31:16]};
    dsc.access = w_hi[15:8];
    dsc.flags  = w_hi[23:20];
  end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
  import seg_desc_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic [1:0]       kind,
  input  logic [BND_W-1:0] bnd,
  input  logic [7:0]       acc,
  output logic             is_null,
  output logic             null_flt,
  output logic             bnd_flt,
  output logic             typ_flt,
  output logic             np_flt
);
  logic [BND_W:0] last_byte;

  always_comb begin
    last_byte = {1'b0, idx, 3'b000} + (BND_W+1)'(7);
    is_null   = (idx == '0);
    null_flt  = is_null && (kind == 2'd1 || kind == 2'd2);
    bnd_flt   = !is_null && (last_byte > {1'b0, bnd});
    typ_flt   = !acc[4];
    np_flt    = acc[4] && !acc[7];
  end
endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl
  import seg_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [1:0]        ld_kind,
  input  logic [TBL_W-1:0]  tbl,
  input  logic [WORD_W-1:0] mem_rdata,
  input  desc_t             raw,
  input  logic              is_null,
  input  logic              null_flt,
  input  logic              bnd_flt,
  input  logic              typ_flt,
  input  logic              np_flt,
  output logic [IDX_W-1:0]  idx_o,
  output logic [1:0]        kind_o,
  output logic [BND_W-1:0]  bnd_o,
  output logic [WORD_W-1:0] w0_o,
  output logic [WORD_W-1:0] w1_o,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              done,
  output logic              vld,
  output logic [1:0]        flt,
  output logic [SEL_W-1:0]  fcode,
  output desc_t             cache
);
  st_e               st_q, st_n;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        kind_q;
  logic [ADDR_W-1:0] tbase_q;
  logic [BND_W-1:0]  tbnd_q;
  logic [WORD_W-1:0] w0_q, w1_q;
  logic              done_q, vld_q, vld_n;
  flt_e              flt_q, flt_n;
  logic [SEL_W-1:0]  fcode_q, fcode_n;
  desc_t             cache_q, cache_n;
  logic              lat_en, w0_en, w1_en, fin_en;
  logic [ADDR_W-1:0] addr0, addr1;
  logic [SEL_W-1:0]  sel_code;

  assign addr0    = tbase_q + ADDR_W'({idx_q, 3'b000});
  assign addr1    = addr0 + ADDR_W'(4);
  assign sel_code = {idx_q, 3'b000};

  always_comb begin
    st_n      = st_q;
    lat_en    = 1'b0;
    w0_en     = 1'b0;
    w1_en     = 1'b0;
    fin_en    = 1'b0;
    vld_n     = vld_q;
    flt_n     = FLT_NONE;
    fcode_n   = '0;
    cache_n   = cache_q;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr0;
    mem_wdata = w1_q | WORD_W'(32'h100);
    case (st_q)
      S_IDLE: if (ld_req) begin
        lat_en = 1'b1;
        st_n   = S_CHK;
      end
      S_CHK: begin
        if (null_flt) begin
          fin_en = 1'b1; vld_n = 1'b0; flt_n = FLT_GP; st_n = S_IDLE;
        end else if (is_null) begin
          fin_en = 1'b1; vld_n = 1'b0; st_n = S_IDLE;
        end else if (bnd_flt) begin
          fin_en = 1'b1; vld_n = 1'b0; flt_n = FLT_GP;
          fcode_n = sel_code; st_n = S_IDLE;
        end else begin
          mem_req = 1'b1;
          st_n    = S_RD1;
        end
      end
      S_RD1: begin
        w0_en    = 1'b1;
        mem_req  = 1'b1;
        mem_addr = addr1;
        st_n     = S_WT;
      end
      S_WT: begin
        w1_en = 1'b1;
        st_n  = S_EVAL;
      end
      S_EVAL: begin
        fin_en = 1'b1;
        st_n   = S_IDLE;
        if (typ_flt) begin
          vld_n = 1'b0; flt_n = FLT_GP; fcode_n = sel_code;
        end else if (np_flt) begin
          vld_n = 1'b0; flt_n = FLT_NP; fcode_n = sel_code;
        end else begin
          vld_n            = 1'b1;
          cache_n          = raw;
          cache_n.access[0] = 1'b1;
          if (!raw.access[0]) begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = addr1;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      done_q  <= 1'b0;
      vld_q   <= 1'b0;
      flt_q   <= FLT_NONE;
      fcode_q <= '0;
    end else begin
      st_q   <= st_n;
      done_q <= fin_en;
      if (fin_en) begin
        vld_q   <= vld_n;
        flt_q   <= flt_n;
        fcode_q <= fcode_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lat_en) begin
      idx_q   <= ld_idx;
      kind_q  <= ld_kind;
      tbase_q <= tbl[TBL_W-1:BND_W];
      tbnd_q  <= tbl[BND_W-1:0];
    end
    if (w0_en) w0_q <= mem_rdata;
    if (w1_en) w1_q <= mem_rdata;
    if (fin_en) cache_q <= cache_n;
  end

  assign idx_o  = idx_q;
  assign kind_o = kind_q;
  assign bnd_o  = tbnd_q;
  assign w0_o   = w0_q;
  assign w1_o   = w1_q;
  assign busy   = (st_q != S_IDLE);
  assign done   = done_q;
  assign vld    = vld_q;
  assign flt    = flt_q;
  assign fcode  = fcode_q;
  assign cache  = cache_q;

  // R10: completion lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R10: a load only starts from a strobe
  a_r10_busy_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(ld_req));
  // R1 / R10: no memory traffic outside a load
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy) |-> !mem_req);
  // R8: write-back always carries the accessed bit
  a_r8_wb_acc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[8]);
  // R4 R5 R6 R7: a fault never leaves a valid cache
  a_r6_fault_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && flt_q != FLT_NONE) |-> !vld_q);
  // R7 R8: a valid result is present, code/data, and accessed
  a_r7_valid_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && vld_q) |-> (cache_q.access[7] && cache_q.access[4] && cache_q.access[0]));
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [1:0]        ld_kind,
  input  logic [TBL_W-1:0]  tbl_reg,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              done,
  output logic              dsc_valid,
  output logic [1:0]        flt_kind,
  output logic [SEL_W-1:0]  flt_code,
  output logic [ADDR_W-1:0] dsc_base,
  output logic [LIM_W-1:0]  dsc_limit,
  output logic [7:0]        dsc_access,
  output logic [3:0]        dsc_flags
);
  logic [IDX_W-1:0]  idx;
  logic [1:0]        kind;
  logic [BND_W-1:0]  bnd;
  logic [WORD_W-1:0] w0, w1;
  desc_t             raw, cache;
  logic              is_null, null_flt, bnd_flt, typ_flt, np_flt;
  logic              unused_sel_lo;

  // R9: requester bits below the index are not used
  assign unused_sel_lo = ^ld_sel[2:0];

  seg_desc_unpack u_unpack (.w_lo(w0), .w_hi(w1), .dsc(raw));

  seg_desc_check u_check (
    .idx(idx), .kind(kind), .bnd(bnd), .acc(raw.access),
    .is_null(is_null), .null_flt(null_flt), .bnd_flt(bnd_flt),
    .typ_flt(typ_flt), .np_flt(np_flt)
  );

  seg_fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_idx(ld_sel[SEL_W-1:3]),
    .ld_kind(ld_kind), .tbl(tbl_reg), .mem_rdata(mem_rdata), .raw(raw),
    .is_null(is_null), .null_flt(null_flt), .bnd_flt(bnd_flt),
    .typ_flt(typ_flt), .np_flt(np_flt),
    .idx_o(idx), .kind_o(kind), .bnd_o(bnd), .w0_o(w0), .w1_o(w1),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .done(done), .vld(dsc_valid), .flt(flt_kind),
    .fcode(flt_code), .cache(cache)
  );

  assign dsc_base   = cache.base;
  assign dsc_limit  = cache.limit;
  assign dsc_access = cache.access;
  assign dsc_flags  = cache.flags;

  // R5: a bound or null fault finishes without any fetch
  a_r5_early_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (is_null || bnd_flt) && !$past(busy)) |-> !mem_req);
endmodule

// File: tb/sim_seg_desc_fetch.sv
module sim_seg_desc_fetch;
  logic        clk, rst_n, ld_req;
  logic [15:0] ld_sel;
  logic [1:0]  ld_kind;
  logic [47:0] tbl_reg;
  logic        busy, mem_req, mem_we, done, dsc_valid;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dsc_base;
  logic [1:0]  flt_kind;
  logic [15:0] flt_code;
  logic [19:0] dsc_limit;
  logic [7:0]  dsc_access;
  logic [3:0]  dsc_flags;

  int nchk = 0, nfail = 0;
  int wr_cnt = 0;
  logic [31:0] rd_addr_q[$];
  logic [31:0] mem [0:63];

  seg_desc_fetch u0 (
    .clk(clk), .rst_n(rst_n), .ld_req(ld_req), .ld_sel(ld_sel), .ld_kind(ld_kind),
    .tbl_reg(tbl_reg), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .dsc_valid(dsc_valid), .flt_kind(flt_kind), .flt_code(flt_code),
    .dsc_base(dsc_base), .dsc_limit(dsc_limit), .dsc_access(dsc_access),
    .dsc_flags(dsc_flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[7:2]];
        rd_addr_q.push_back(mem_addr);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_entry(input int i, input logic [31:0] b, input logic [19:0] l,
                           input logic [7:0] a, input logic [3:0] f);
    mem[16 + 2*i]     = {b[15:0], l[15:0]};
    mem[16 + 2*i + 1] = {b[31:24], f, l[19:16], a, b[23:16]};
  endtask

  // Behavioural model: derive the outcome from the requirements, then
  // compare busy/done every cycle and the result on the done cycle.
  task automatic run_load(input logic [15:0] sel, input logic [1:0] kind,
                          input bit inject, input string tag);
    int idx, lat, bnd, tb, wb_exp, wr0;
    logic [31:0] w0, w1;
    logic [7:0] acc;
    logic [1:0] ek;
    logic [15:0] ec;
    logic ev;
    idx = int'(sel >> 3);
    tb  = int'(tbl_reg[47:16]);
    bnd = int'(tbl_reg[15:0]);
    wb_exp = 0; ek = 0; ec = 0; ev = 0; lat = 1; w0 = 0; w1 = 0; acc = 0;
    if (idx == 0) begin
      if (kind == 2'd1 || kind == 2'd2) ek = 2'd1;
    end else if (idx*8 + 7 > bnd) begin
      ek = 2'd1; ec = {sel[15:3], 3'b000};
    end else begin
      lat = 4;
      w0 = mem[((tb + idx*8) >> 2) & 63];
      w1 = mem[((tb + idx*8 + 4) >> 2) & 63];
      acc = w1[15:8];
      if (!acc[4]) begin ek = 2'd1; ec = {sel[15:3], 3'b000}; end
      else if (!acc[7]) begin ek = 2'd2; ec = {sel[15:3], 3'b000}; end
      else begin ev = 1; wb_exp = !acc[0]; end
    end
    wr0 = wr_cnt;
    rd_addr_q.delete();
    @(negedge clk);
    ld_req = 1'b1; ld_sel = sel; ld_kind = kind;
    @(negedge clk);
    ld_req = 1'b0;
    for (int j = 0; j <= lat; j++) begin
      if (j > 0) @(negedge clk);
      if (inject && j == 1) begin ld_req = 1'b1; ld_sel = 16'h0008; ld_kind = 2'd1; end
      if (inject && j == 2) ld_req = 1'b0;
      chk({tag, " R10 busy"}, 64'(busy), 64'(j < lat));
      chk({tag, " R10 done"}, 64'(done), 64'(j == lat));
    end
    chk({tag, " flt_kind"}, 64'(flt_kind), 64'(ek));
    chk({tag, " flt_code"}, 64'(flt_code), 64'(ec));
    chk({tag, " dsc_valid"}, 64'(dsc_valid), 64'(ev));
    if (ev) begin
      chk({tag, " R3 base"}, 64'(dsc_base), 64'({w1[31:24], w1[7:0], w0[31:16]}));
      chk({tag, " R3 limit"}, 64'(dsc_limit), 64'({w1[19:16], w0[15:0]}));
      chk({tag, " R3 flags"}, 64'(dsc_flags), 64'(w1[23:20]));
      chk({tag, " R8 access"}, 64'(dsc_access), 64'(acc | 8'h01));
    end
    @(negedge clk);
    chk({tag, " R10 done low"}, 64'(done), 64'(0));
    chk({tag, " R10 idle"}, 64'(busy), 64'(0));
    chk({tag, " R8 writes"}, 64'(wr_cnt - wr0), 64'(wb_exp));
    if (wb_exp)
      chk({tag, " R8 wb data"}, 64'(mem[((tb + idx*8 + 4) >> 2) & 63]), 64'(w1 | 32'h100));
    if (lat == 4) begin
      chk({tag, " R2 reads"}, 64'(rd_addr_q.size()), 64'(2));
      if (rd_addr_q.size() == 2) begin
        chk({tag, " R2 addr0"}, 64'(rd_addr_q[0]), 64'(tb + idx*8));
        chk({tag, " R2 addr1"}, 64'(rd_addr_q[1]), 64'(tb + idx*8 + 4));
      end
    end else begin
      chk({tag, " no fetch"}, 64'(rd_addr_q.size()), 64'(0));
    end
  endtask

  initial begin
    #(4*150000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h0;
    mem_rdata = 32'h0;
    put_entry(1, 32'h12345678, 20'hABCDE, 8'h9A, 4'hC);
    put_entry(2, 32'h00000000, 20'hFFFFF, 8'h93, 4'hC);
    put_entry(3, 32'h0000A000, 20'h00FFF, 8'h12, 4'h4);
    put_entry(4, 32'h00B00000, 20'h00067, 8'h89, 4'h0);
    put_entry(5, 32'hC0000000, 20'h00010, 8'h09, 4'h0);
    put_entry(6, 32'hFEDCBA98, 20'h76543, 8'hF2, 4'h8);
    put_entry(7, 32'h11223344, 20'h55667, 8'hFB, 4'hC);
    ld_req = 1'b0; ld_sel = 16'h0; ld_kind = 2'd0;
    tbl_reg = {32'h0000_0040, 16'h003F};
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 done", 64'(done), 64'(0));
    chk("R1 valid", 64'(dsc_valid), 64'(0));
    chk("R1 flt", 64'(flt_kind), 64'(0));
    chk("R1 mem_req", 64'(mem_req), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run_load(16'h0008, 2'd1, 0, "R2 R3 R8 code entry wb");
    run_load(16'h0008, 2'd1, 0, "R8 entry already accessed");
    run_load(16'h0017, 2'd0, 0, "R9 low bits set data");
    run_load(16'h0010, 2'd3, 0, "R9 low bits clear data");
    run_load(16'h0003, 2'd0, 0, "R4 null data");
    run_load(16'h0005, 2'd1, 0, "R4 null code");
    run_load(16'h0000, 2'd2, 0, "R4 null stack");
    run_load(16'h001A, 2'd0, 0, "R7 not present");
    run_load(16'h0020, 2'd0, 0, "R6 system entry");
    run_load(16'h0028, 2'd2, 0, "R6 system over not present");
    run_load(16'h0030, 2'd2, 0, "R8 user data wb");
    run_load(16'h003B, 2'd1, 0, "R9 user code");
    tbl_reg = {32'h0000_0040, 16'h002F};
    put_entry(5, 32'hC0000000, 20'h00010, 8'h92, 4'h4);
    run_load(16'h0028, 2'd0, 0, "R5 last entry at boundary");
    run_load(16'h0030, 2'd0, 0, "R5 past boundary");
    run_load(16'h0037, 2'd1, 0, "R5 R9 past boundary low bits");
    tbl_reg = {32'h0000_0040, 16'h003F};
    put_entry(7, 32'h0BADF00D, 20'h12345, 8'h92, 4'hC);
    run_load(16'h0038, 2'd0, 1, "R10 strobe while busy");
    run_load(16'h0000, 2'd0, 0, "R4 null clears valid");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule